// File: doc/BRIEF.md
# DMA Channel Request Gating Arbiter

This block decides, once per clock cycle, which DMA channel may move one data element. It looks at each channel's configuration word and control word. From them it takes the channel enable, the halt bit, the flow-control type, the source and destination peripheral numbers and the remaining element count. It combines these with a 32-bit peripheral request vector, which is the OR of the single-request and burst-request inputs. The result is one eligible/ineligible decision per channel.

Among the eligible channels, one is selected and registered as a one-hot grant with a valid strobe. The grant is held for one cycle per element. A channel that is granted keeps the grant for as long as it stays eligible. When it drops out, the scan continues upward from that channel, and it wraps to the lowest index only when nothing above is eligible. With no grant in flight, the lowest eligible index wins. The data mover and the descriptor loader sit outside this block. They consume the grant and update the count and configuration words that feed back in.

Top module: `dma_req_arbiter`

## Requirements
- R1: A channel can be granted only when its configuration bit 0 (enable) is 1 and its configuration bit 18 (halt) is 0.
- R2: Configuration bits 13:11 hold the flow type, bits 5:1 the source peripheral number and bits 10:6 the destination peripheral number.
- R3: Flow type 0 needs no peripheral request. Flow type 1 needs the destination peripheral's request bit, flow type 2 needs the source peripheral's request bit, and flow type 3 needs both.
- R4: The request bit of peripheral p is req_single[p] OR req_burst[p]; either input alone satisfies a flow requirement.
- R5: A channel whose remaining count (control bits 11:0) is zero is never granted.
- R6: Flow types 4 to 7 make a channel ineligible. For an enabled, unhalted channel they set that channel's flow_err bit one cycle later.
- R7: When no grant was issued in the previous cycle, the lowest-index eligible channel is granted.
- R8: A channel granted in the previous cycle that is still eligible is granted again, whatever lower-index channels request.
- R9: When the previously granted channel is no longer eligible, the lowest eligible channel above it is granted. If none above is eligible, the lowest eligible channel overall is granted.
- R10: While glb_en is 0, no grant is issued.
- R11: The grant is registered: inputs sampled at one clock edge decide grant and grant_vld after that edge. grant is one-hot when grant_vld is 1 and zero otherwise, and reset clears both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| glb_en | input | 1 | Global controller enable |
| chan_cfg | input | NUM_CH*32 | Per-channel configuration words, channel c at bits c*32+31:c*32 |
| chan_ctl | input | NUM_CH*32 | Per-channel control words, count in bits 11:0 of each |
| req_single | input | 32 | Single-transfer peripheral requests |
| req_burst | input | 32 | Burst-transfer peripheral requests |
| grant | output | NUM_CH | One-hot registered grant |
| grant_vld | output | 1 | One element granted this cycle |
| flow_err | output | NUM_CH | Registered unsupported-flow flag per channel |

## Verification
The bench sweeps one channel through every flow type, enable, halt, zero-count and request combination. Source and destination requests arrive through alternating single and burst inputs. A design with swapped peripheral fields or a missing OR term would grant when it should stall, or stall when it should grant. It then steps through every eligibility subset of a four-channel instance, with and without the global enable, to catch a wrong priority order or a grant that leaks while disabled. A long pseudo-random walk compares every cycle against an arithmetic model of the hold and scan-upward rule. A design that released a still-eligible channel, or restarted at index 0 instead of moving upward, would pick the wrong channel there.

// File: rtl/dma_arb_pkg.sv
// Package: shared field positions and flow-type codes for the channel arbiter.
// Assumes 32-bit configuration and control words per channel.
package dma_arb_pkg;
    localparam int WORD_W     = 32;
    localparam int PERIPH_W   = 5;
    localparam int CNT_W      = 12;
    localparam int EN_BIT     = 0;
    localparam int HALT_BIT   = 18;
    localparam int SRC_LSB    = 1;
    localparam int DST_LSB    = 6;
    localparam int FLOW_LSB   = 11;
    localparam int FLOW_W     = 3;

    typedef enum logic [2:0] {
        FLOW_MEM   = 3'd0,
        FLOW_TO_P  = 3'd1,
        FLOW_FROM_P = 3'd2,
        FLOW_P_TO_P = 3'd3
    } flow_e;
endpackage

// File: rtl/dma_ch_gate.sv
// Module: per-channel eligibility gate.
// Decodes one channel's configuration and control words and reports whether the
// channel may move an element now, plus whether its flow type is unsupported.
// Assumes the request vector is already the OR of single and burst requests.
module dma_ch_gate
    import dma_arb_pkg::*;
(
    input  logic [WORD_W-1:0] cfg,
    input  logic [WORD_W-1:0] ctl,
    input  logic [31:0]       req,
    output logic              eligible,
    output logic              flow_bad
);
    logic [PERIPH_W-1:0] src_p;
    logic [PERIPH_W-1:0] dst_p;
    logic [FLOW_W-1:0]   flow;
    logic                armed;
    logic                cnt_nz;
    logic                req_ok;
    logic                unused_bits;

    assign src_p  = cfg[SRC_LSB +: PERIPH_W];
    assign dst_p  = cfg[DST_LSB +: PERIPH_W];
    assign flow   = cfg[FLOW_LSB +: FLOW_W];
    assign armed  = cfg[EN_BIT] && !cfg[HALT_BIT];
    assign cnt_nz = |ctl[CNT_W-1:0];
    assign unused_bits = ^{cfg[31:19], cfg[17:14], ctl[31:12]};

    // Purpose: check the peripheral requests that the flow type calls for.
    always_comb begin
        case (flow)
            FLOW_MEM:    req_ok = 1'b1;
            FLOW_TO_P:   req_ok = req[dst_p];
            FLOW_FROM_P: req_ok = req[src_p];
            FLOW_P_TO_P: req_ok = req[src_p] && req[dst_p];
            default:     req_ok = 1'b0;
        endcase
    end

    // Purpose: combine enable, halt, count and request tests into eligibility.
    always_comb begin
        eligible = armed && cnt_nz && req_ok && !flow[FLOW_W-1];
        flow_bad = armed && flow[FLOW_W-1];
    end
endmodule

// File: rtl/dma_prio_pick.sv
// Module: fixed-priority picker, lowest set index wins.
// Output is one-hot or zero; any_hit reports whether any request was set.
module dma_prio_pick #(
    parameter int N = 8
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] pick,
    output logic         any_hit
);
    // Purpose: scan upward and keep only the first set bit.
    always_comb begin
        logic found;
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                pick[i] = 1'b1;
                found   = 1'b1;
            end
        end
        any_hit = found;
    end
endmodule

// File: rtl/dma_req_arbiter.sv
// Module: DMA channel request gating arbiter (top).
// Gates every channel against its configuration, count and peripheral requests.
// Holds the current channel while it stays eligible, otherwise scans upward and
// wraps, and registers a one-hot grant with a valid strobe.
// Assumes the count and configuration words are updated externally after each element.
module dma_req_arbiter
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     glb_en,
    input  logic [NUM_CH*WORD_W-1:0] chan_cfg,
    input  logic [NUM_CH*WORD_W-1:0] chan_ctl,
    input  logic [31:0]              req_single,
    input  logic [31:0]              req_burst,
    output logic [NUM_CH-1:0]        grant,
    output logic                     grant_vld,
    output logic [NUM_CH-1:0]        flow_err
);
    logic [31:0]       req_any;
    logic [NUM_CH-1:0] elig;
    logic [NUM_CH-1:0] bad;
    logic [NUM_CH-1:0] above;
    logic [NUM_CH-1:0] hold_hit;
    logic [NUM_CH-1:0] pick_up;
    logic [NUM_CH-1:0] pick_all;
    logic              up_any;
    logic              all_any;
    logic [NUM_CH-1:0] nxt_grant;
    logic [NUM_CH-1:0] grant_q;
    logic              vld_q;
    logic [NUM_CH-1:0] bad_q;

    assign req_any = req_single | req_burst;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dma_ch_gate u_gate (
            .cfg      (chan_cfg[c*WORD_W +: WORD_W]),
            .ctl      (chan_ctl[c*WORD_W +: WORD_W]),
            .req      (req_any),
            .eligible (elig[c]),
            .flow_bad (bad[c])
        );
    end

    // Purpose: mark channels above the one granted last cycle.
    always_comb begin
        logic seen;
        seen = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            above[i] = seen;
            seen     = seen | grant_q[i];
        end
    end

    assign hold_hit = elig & grant_q;

    dma_prio_pick #(.N(NUM_CH)) u_pick_up (
        .req     (elig & above),
        .pick    (pick_up),
        .any_hit (up_any)
    );

    dma_prio_pick #(.N(NUM_CH)) u_pick_all (
        .req     (elig),
        .pick    (pick_all),
        .any_hit (all_any)
    );

    // Purpose: choose hold, continue upward, or wrap to the lowest channel.
    always_comb begin
        if (!glb_en)          nxt_grant = '0;
        else if (|hold_hit)   nxt_grant = hold_hit;
        else if (up_any)      nxt_grant = pick_up;
        else if (all_any)     nxt_grant = pick_all;
        else                  nxt_grant = '0;
    end

    // Purpose: register grant, valid and unsupported-flow flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= '0;
            vld_q   <= 1'b0;
            bad_q   <= '0;
        end else begin
            grant_q <= nxt_grant;
            vld_q   <= |nxt_grant;
            bad_q   <= bad;
        end
    end

    assign grant     = grant_q;
    assign grant_vld = vld_q;
    assign flow_err  = bad_q;

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |-> ($countones(grant_q) == 1)); // R11
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_q |-> (grant_q == '0)); // R11
    AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |=> !vld_q); // R10

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        AST_ARMED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
            grant_q[c] |-> $past(chan_cfg[c*WORD_W+EN_BIT] && !chan_cfg[c*WORD_W+HALT_BIT])); // R1
        AST_COUNT_NZ: assert property (@(posedge clk) disable iff (!rst_n)
            grant_q[c] |-> $past(chan_ctl[c*WORD_W +: CNT_W] != '0)); // R5
        AST_FLOW_OK: assert property (@(posedge clk) disable iff (!rst_n)
            grant_q[c] |-> $past(!chan_cfg[c*WORD_W+FLOW_LSB+FLOW_W-1])); // R6
        AST_BAD_NOGRANT: assert property (@(posedge clk) disable iff (!rst_n)
            bad_q[c] |-> !grant_q[c]); // R6
        AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (grant_q[c] && elig[c] && glb_en) |=> grant_q[c]); // R8
    end
endmodule

// File: tb/dma_req_arbiter_bench.sv
module dma_req_arbiter_bench;
    localparam int NCH = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            glb_en = 1'b0;
    logic [NCH*32-1:0] chan_cfg = '0;
    logic [NCH*32-1:0] chan_ctl = '0;
    logic [31:0]     req_single = '0;
    logic [31:0]     req_burst = '0;
    logic [NCH-1:0]  grant;
    logic            grant_vld;
    logic [NCH-1:0]  flow_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dma_req_arbiter #(.NUM_CH(NCH)) u_dma_req_arbiter (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en),
        .chan_cfg(chan_cfg), .chan_ctl(chan_ctl),
        .req_single(req_single), .req_burst(req_burst),
        .grant(grant), .grant_vld(grant_vld), .flow_err(flow_err)
    );

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_cfg(input bit en, input bit halt, input int flow,
                                            input int sp, input int dp);
        logic [31:0] w;
        w = '0;
        w[0] = en;
        w[5:1] = sp[4:0];
        w[10:6] = dp[4:0];
        w[13:11] = flow[2:0];
        w[18] = halt;
        return w;
    endfunction

    // expected next grant from previous grant, eligibility and enable
    function automatic logic [NCH-1:0] model(input logic [NCH-1:0] prev, input logic [NCH-1:0] el, input bit en);
        int p;
        if (!en) return '0;
        if ((prev & el) != 0) return prev & el;
        p = -1;
        for (int i = 0; i < NCH; i++) if (prev[i]) p = i;
        if (p >= 0)
            for (int i = p + 1; i < NCH; i++) if (el[i]) return NCH'(1) << i;
        for (int i = 0; i < NCH; i++) if (el[i]) return NCH'(1) << i;
        return '0;
    endfunction

    // set channel eligibility by mask using memory flow and nonzero count
    task automatic set_mask(input logic [NCH-1:0] m);
        for (int c = 0; c < NCH; c++) begin
            chan_cfg[c*32 +: 32] = mk_cfg(1'b1, 1'b0, 0, c, c + 8);
            chan_ctl[c*32 +: 32] = m[c] ? 32'hABC0_0005 : 32'hABC0_0000;
        end
    endtask

    logic [NCH-1:0] exp_g;

    task automatic step_mask(input logic [NCH-1:0] m, input bit en, input string tag);
        @(negedge clk);
        set_mask(m);
        glb_en = en;
        exp_g = model(exp_g, m, en);
        @(negedge clk);
        check(grant == exp_g && grant_vld == (exp_g != 0), tag, {11'd0, grant_vld, grant}, {11'd0, exp_g != 0, exp_g});
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int k;
        logic [15:0] lf;
        // reset with an eligible channel present: R11
        glb_en = 1'b1;
        set_mask(4'b0001);
        repeat (3) @(negedge clk);
        check(grant == 0 && !grant_vld && flow_err == 0, "R11 reset", {11'd0, grant_vld, grant}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(grant == 4'b0001 && grant_vld, "R11 first grant", {11'd0, grant_vld, grant}, 16'h0011);

        // exhaustive single-channel sweep: R1 R2 R3 R4 R5 R6
        k = 0;
        for (int fl = 0; fl < 8; fl++)
        for (int en = 0; en < 2; en++)
        for (int hl = 0; hl < 2; hl++)
        for (int cz = 0; cz < 2; cz++)
        for (int rq = 0; rq < 4; rq++) begin
            int sp, dp;
            bit s_on, d_on, need, el, bf;
            sp = k % 32;
            dp = 31 - (k % 32);
            if (dp == sp) dp = (sp + 1) % 32;
            s_on = rq[0];
            d_on = rq[1];
            @(negedge clk);
            chan_cfg = '0;
            chan_ctl = '0;
            chan_cfg[31:0] = mk_cfg(en[0], hl[0], fl, sp, dp);
            chan_ctl[31:0] = cz ? 32'hFFFF_F000 : {20'hFFFFF, 12'(k + 1)};
            req_single = '0;
            req_burst = '0;
            // route requests alternately through single and burst inputs (R4)
            if (s_on) begin if (k % 2 == 0) req_single[sp] = 1'b1; else req_burst[sp] = 1'b1; end
            if (d_on) begin if (k % 2 == 0) req_burst[dp] = 1'b1; else req_single[dp] = 1'b1; end
            glb_en = 1'b1;
            case (fl)
                0: need = 1'b1;
                1: need = d_on;
                2: need = s_on;
                3: need = s_on && d_on;
                default: need = 1'b0;
            endcase
            el = en && !hl && !cz && need;
            bf = en && !hl && (fl >= 4);
            @(negedge clk);
            check(grant == {3'b000, el} && grant_vld == el && flow_err == {3'b000, bf},
                  "R1 R2 R3 R4 R5 R6 gate sweep",
                  {7'd0, flow_err, grant_vld, grant}, {7'd0, 3'b000, bf, el, 3'b000, el});
            k++;
        end
        req_single = '0;
        req_burst = '0;

        // every subset, disabled then enabled from idle: R10 R7
        for (int m = 0; m < 16; m++) begin
            exp_g = '0;
            step_mask(m[NCH-1:0], 1'b0, "R10 global off");
            step_mask(m[NCH-1:0], 1'b1, "R7 lowest index");
        end

        // directed hold and scan-upward cases: R8 R9
        step_mask(4'b0000, 1'b0, "R10 idle");
        step_mask(4'b0100, 1'b1, "R7 single");
        step_mask(4'b0101, 1'b1, "R8 hold over lower");
        step_mask(4'b1001, 1'b1, "R9 move upward");
        check(grant == 4'b1000, "R9 upward value", {12'd0, grant}, 16'h0008);
        step_mask(4'b0011, 1'b1, "R9 wrap to lowest");
        check(grant == 4'b0001, "R9 wrap value", {12'd0, grant}, 16'h0001);

        // pseudo-random walk against model: R8 R9 R10
        lf = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step_mask(lf[3:0] | (lf[6] ? exp_g : 4'b0000), lf[9:7] != 3'b000, "R8 R9 random walk");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule